// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the one-bit storage element that sits behind the sum-of-products logic of a programmable-logic macrocell. A set of static configuration inputs turns the same bit into any of these: a D, T, JK or SR flip-flop, a transparent latch, or a bit that simply holds its value. The same inputs choose where the data comes from, which clock drives the bit, whether an enable term gates that clock, and which terms clear or set the bit without waiting for a clock.

The element is built as a sampled model inside a synchronous design. A fast system clock `clk` samples the macrocell clock inputs `glob_clk` and `term_clk`. A rising edge of the selected macrocell clock is seen as a change from low to high between two samples, and the bit updates on the system-clock edge that sees it. The clear, preset and latch pass-through paths reach `q` through combinational logic, so they act within the same cycle. Each level on a macrocell clock input must be held for at least one system-clock cycle. In latch mode, the data must be held for one cycle before the latch clock falls.

Top module: `mc_storage_cell`

## Requirements
- R1: `cfg_dsrc` picks the data value: 00 the XOR result `xor_in`, 01 the dedicated term `data_term`, 10 the pin value `pin_in`, 11 also `xor_in`.
- R2: With `cfg_mode` = 000 (D), a rising edge of the selected clock loads the data value. With no accepted edge the stored bit is unchanged.
- R3: With `cfg_mode` = 001 (T), an accepted edge inverts the bit when the data value is 1 and keeps it when the data value is 0.
- R4: With `cfg_mode` = 010 (JK), an accepted edge gives: J=0 K=0 hold, J=1 K=0 set, J=0 K=1 clear, J=1 K=1 invert.
- R5: With `cfg_mode` = 011 (SR), an accepted edge gives: S=1 R=0 set, S=0 R=1 clear, and hold when S and R are equal.
- R6: With `cfg_mode` = 100 (latch), `q` follows the data value while the selected clock is high, and keeps the last value passed while the clock is low.
- R7: `cfg_clk_sel` = 0 selects `glob_clk` and 1 selects `term_clk`. Edges on the clock that is not selected have no effect.
- R8: When `glob_clk` is selected and `cfg_ce_en` = 1, any edge seen while `en_term` is low is ignored. When `term_clk` is selected, `en_term` has no effect.
- R9: `cfg_clr_sel` sets the clear source: 00 none, 01 `glob_clr`, 10 `clr_term`, 11 either of them. An active clear forces `q` to 0 at once, and the bit stays 0.
- R10: With `cfg_pre_en` = 1, `set_term` forces `q` to 1 at once. When clear and preset are active together, clear wins. Both override any clocked or latch behaviour.
- R11: `cfg_mode` values 101, 110 and 111 hold the stored bit through clock edges.
- R12: With `rst_n` low at a rising edge of `clk`, the stored bit becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Operating mode code |
| cfg_dsrc | input | 2 | Data source select |
| cfg_clk_sel | input | 1 | 0 global clock, 1 product-term clock |
| cfg_ce_en | input | 1 | Use `en_term` as clock enable (global clock only) |
| cfg_clr_sel | input | 2 | Clear source select |
| cfg_pre_en | input | 1 | Enable preset from `set_term` |
| xor_in | input | 1 | XOR gate result |
| data_term | input | 1 | Dedicated data product term |
| pin_in | input | 1 | I/O pin value |
| j_in | input | 1 | J term |
| k_in | input | 1 | K term |
| s_in | input | 1 | S term |
| r_in | input | 1 | R term |
| glob_clk | input | 1 | Global macrocell clock |
| term_clk | input | 1 | Product-term macrocell clock |
| en_term | input | 1 | Clock-enable product term |
| glob_clr | input | 1 | Global clear |
| clr_term | input | 1 | Clear product term |
| set_term | input | 1 | Preset product term |
| q | output | 1 | Stored value |

## Verification
The embedded assertions check these rules on every cycle: clear forces a zero and preset a one, with clear winning; the bit keeps its value when no edge is accepted; the enable term blocks edges; the reserved modes hold; JK toggles when both terms are high; SR holds when both terms are high. What only the bench scenarios can show is the value `q` takes: which data source each `cfg_dsrc` code selects, that the latch is transparent and then holds, that the clock that is not selected is ignored, and that `en_term` has no effect on the product-term clock. A reference model in the bench checks these at the ports under random configuration changes and directed sequences.

// File: rtl/mc_cell_pkg.sv
`timescale 1ns/1ps
// Package: shared codes for the macrocell storage element.
// Assumes: configuration fields arrive as plain vectors and are cast here.
package mc_cell_pkg;
    localparam int MODE_W = 3;
    localparam int DSRC_W = 2;
    localparam int CLR_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_D     = 3'b000,
        MODE_T     = 3'b001,
        MODE_JK    = 3'b010,
        MODE_SR    = 3'b011,
        MODE_LATCH = 3'b100
    } cell_mode_e;

    typedef enum logic [DSRC_W-1:0] {
        DSRC_XOR   = 2'b00,
        DSRC_TERM  = 2'b01,
        DSRC_PIN   = 2'b10,
        DSRC_XOR_B = 2'b11
    } data_src_e;

    // Clear select bits: bit 0 enables the global clear, bit 1 the clear term.
    localparam int CLR_GLOBAL_BIT = 0;
    localparam int CLR_TERM_BIT   = 1;
endpackage

// File: rtl/mc_data_select.sv
`timescale 1ns/1ps
// Module: mc_data_select
// Picks the data value for the storage bit from the XOR result, the
// dedicated product term or the pin. Assumes a static select; purely combinational.
module mc_data_select
    import mc_cell_pkg::*;
(
    input  logic [DSRC_W-1:0] dsrc,
    input  logic              xor_in,
    input  logic              data_term,
    input  logic              pin_in,
    output logic              d_out
);
    // Source multiplexer; both unused codes fall back to the XOR result.
    always_comb begin
        case (data_src_e'(dsrc))
            DSRC_TERM: d_out = data_term;
            DSRC_PIN:  d_out = pin_in;
            default:   d_out = xor_in;
        endcase
    end
endmodule

// File: rtl/mc_clock_ctrl.sv
`timescale 1ns/1ps
// Module: mc_clock_ctrl
// Samples both macrocell clocks on the system clock and reports the level of
// the selected clock and an accepted rising edge. The enable term gates edges
// only while the global clock is selected. Assumes each macrocell clock level
// lasts at least one system cycle.
module mc_clock_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_sel,
    input  logic ce_en,
    input  logic glob_clk,
    input  logic term_clk,
    input  logic en_term,
    output logic level_o,
    output logic rise_o
);
    logic glob_prev;
    logic term_prev;
    logic prev_sel;
    logic ce_block;

    // Remember the last sampled level of each clock independently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_prev <= 1'b0;
            term_prev <= 1'b0;
        end else begin
            glob_prev <= glob_clk;
            term_prev <= term_clk;
        end
    end

    // Select the clock, find its rising edge and apply the enable gate.
    always_comb begin
        level_o  = clk_sel ? term_clk : glob_clk;
        prev_sel = clk_sel ? term_prev : glob_prev;
        ce_block = !clk_sel && ce_en && !en_term;
        rise_o   = level_o && !prev_sel && !ce_block;
    end

    // An accepted edge only exists while the selected clock is high (R7).
    assert_rise_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> level_o);

    // A low enable term on the global clock blocks every edge (R8).
    assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_sel && ce_en && !en_term) |-> !rise_o);
endmodule

// File: rtl/mc_next_state.sv
`timescale 1ns/1ps
// Module: mc_next_state
// Computes the value the bit takes when it is written, for each mode.
// Assumes the caller decides when a write happens; purely combinational.
module mc_next_state
    import mc_cell_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              cur,
    input  logic              d,
    input  logic              j,
    input  logic              k,
    input  logic              s,
    input  logic              r,
    output logic              nxt
);
    // Per-mode next-state function; reserved codes keep the current bit.
    always_comb begin
        nxt = cur;
        case (cell_mode_e'(mode))
            MODE_D:     nxt = d;
            MODE_T:     nxt = cur ^ d;
            MODE_JK: begin
                case ({j, k})
                    2'b10:   nxt = 1'b1;
                    2'b01:   nxt = 1'b0;
                    2'b11:   nxt = !cur;
                    default: nxt = cur;
                endcase
            end
            MODE_SR: begin
                if (s && !r)      nxt = 1'b1;
                else if (r && !s) nxt = 1'b0;
                else              nxt = cur;
            end
            MODE_LATCH: nxt = d;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/mc_storage_cell.sv
`timescale 1ns/1ps
// Module: mc_storage_cell (top)
// One configurable storage bit of a macrocell: D/T/JK/SR flip-flop or
// transparent latch, with selectable data source, clock, clock enable and
// clear/preset sources. Clear and preset reach q combinationally and also
// force the stored bit. Assumes static configuration between uses.
module mc_storage_cell
    import mc_cell_pkg::*;
#(
    parameter logic RESET_STATE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [DSRC_W-1:0] cfg_dsrc,
    input  logic              cfg_clk_sel,
    input  logic              cfg_ce_en,
    input  logic [CLR_W-1:0]  cfg_clr_sel,
    input  logic              cfg_pre_en,
    input  logic              xor_in,
    input  logic              data_term,
    input  logic              pin_in,
    input  logic              j_in,
    input  logic              k_in,
    input  logic              s_in,
    input  logic              r_in,
    input  logic              glob_clk,
    input  logic              term_clk,
    input  logic              en_term,
    input  logic              glob_clr,
    input  logic              clr_term,
    input  logic              set_term,
    output logic              q
);
    logic d_sel;
    logic level;
    logic rise;
    logic nxt;
    logic state;
    logic is_latch;
    logic write_en;
    logic clr_act;
    logic pre_act;
    logic reserved_mode;

    mc_data_select u_data (
        .dsrc      (cfg_dsrc),
        .xor_in    (xor_in),
        .data_term (data_term),
        .pin_in    (pin_in),
        .d_out     (d_sel)
    );

    mc_clock_ctrl u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_sel  (cfg_clk_sel),
        .ce_en    (cfg_ce_en),
        .glob_clk (glob_clk),
        .term_clk (term_clk),
        .en_term  (en_term),
        .level_o  (level),
        .rise_o   (rise)
    );

    mc_next_state u_next (
        .mode (cfg_mode),
        .cur  (state),
        .d    (d_sel),
        .j    (j_in),
        .k    (k_in),
        .s    (s_in),
        .r    (r_in),
        .nxt  (nxt)
    );

    // Decode the mode class and the asynchronous controls.
    always_comb begin
        is_latch      = (cell_mode_e'(cfg_mode) == MODE_LATCH);
        reserved_mode = (cfg_mode > MODE_LATCH);
        write_en      = is_latch ? level : rise;
        clr_act       = (cfg_clr_sel[CLR_GLOBAL_BIT] && glob_clr) ||
                        (cfg_clr_sel[CLR_TERM_BIT] && clr_term);
        pre_act       = cfg_pre_en && set_term;
    end

    // Storage bit: reset, then clear, then preset, then a normal write.
    always_ff @(posedge clk) begin
        if (!rst_n)        state <= RESET_STATE;
        else if (clr_act)  state <= 1'b0;
        else if (pre_act)  state <= 1'b1;
        else if (write_en) state <= nxt;
    end

    // Output: clear and preset win at once; an open latch passes data through.
    always_comb begin
        if (clr_act)                q = 1'b0;
        else if (pre_act)           q = 1'b1;
        else if (is_latch && level) q = d_sel;
        else                        q = state;
    end

    // The bit holds when there is no write and no forcing control (R2).
    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!write_en && !clr_act && !pre_act) |=> $stable(state));

    // JK with both terms high inverts the bit on an accepted edge (R4).
    assert_jk_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_JK && rise && j_in && k_in && !clr_act && !pre_act)
        |=> (state != $past(state)));

    // SR with both terms high keeps the bit (R5).
    assert_sr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_SR && s_in && r_in && !clr_act && !pre_act)
        |=> $stable(state));

    // An active clear leaves the stored bit at zero (R9).
    assert_clear_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (state == 1'b0));

    // A preset without a clear leaves the stored bit at one (R10).
    assert_preset_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_act && !clr_act) |=> (state == 1'b1));

    // Reserved mode codes never change the bit on their own (R11).
    assert_reserved_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reserved_mode && !clr_act && !pre_act) |=> $stable(state));
endmodule

// File: tb/test_mc_storage_cell.sv
`timescale 1ns/1ps
// Bench for mc_storage_cell: directed corner cases then seeded random steps,
// each compared against a reference model built from the requirements.
module test_mc_storage_cell;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cfg_mode;
    logic [1:0] cfg_dsrc;
    logic       cfg_clk_sel, cfg_ce_en, cfg_pre_en;
    logic [1:0] cfg_clr_sel;
    logic       xor_in, data_term, pin_in, j_in, k_in, s_in, r_in;
    logic       glob_clk, term_clk, en_term, glob_clr, clr_term, set_term;
    logic       q;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    logic m_state, m_prev_g, m_prev_p;

    always #2 clk = ~clk;   // 250 MHz

    mc_storage_cell i_mc_storage_cell (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_dsrc(cfg_dsrc),
        .cfg_clk_sel(cfg_clk_sel), .cfg_ce_en(cfg_ce_en),
        .cfg_clr_sel(cfg_clr_sel), .cfg_pre_en(cfg_pre_en),
        .xor_in(xor_in), .data_term(data_term), .pin_in(pin_in),
        .j_in(j_in), .k_in(k_in), .s_in(s_in), .r_in(r_in),
        .glob_clk(glob_clk), .term_clk(term_clk), .en_term(en_term),
        .glob_clr(glob_clr), .clr_term(clr_term), .set_term(set_term), .q(q)
    );

    // R1 reference: source codes 01 term, 10 pin, 00/11 XOR.
    function automatic logic ref_data(logic [1:0] src, logic x, logic t, logic p);
        if (src == 2'b01) return t;
        if (src == 2'b10) return p;
        return x;
    endfunction

    // R2..R6, R11 reference next value on a write.
    function automatic logic ref_next(logic [2:0] m, logic c, logic d,
                                      logic j, logic k, logic s, logic r);
        case (m)
            3'd0: return d;
            3'd1: return d ? !c : c;
            3'd2: return (j && k) ? !c : (j ? 1'b1 : (k ? 1'b0 : c));
            3'd3: return (s == r) ? c : s;
            3'd4: return d;
            default: return c;
        endcase
    endfunction

    function automatic string tag_for(logic clr, logic pre, logic [2:0] m);
        if (clr) return "R9";
        if (pre) return "R10";
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: q=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One system cycle: predict, let the edge pass, compare at the negedge.
    task automatic step(string tag);
        logic sel, psel, edge_ok, d, clr, pre, wr, exp_q;
        string t;
        sel     = cfg_clk_sel ? term_clk : glob_clk;
        psel    = cfg_clk_sel ? m_prev_p : m_prev_g;
        edge_ok = sel && !psel && !(!cfg_clk_sel && cfg_ce_en && !en_term);
        d       = ref_data(cfg_dsrc, xor_in, data_term, pin_in);
        clr     = (cfg_clr_sel[0] && glob_clr) || (cfg_clr_sel[1] && clr_term);
        pre     = cfg_pre_en && set_term;
        wr      = (cfg_mode == 3'd4) ? sel : edge_ok;
        if (!rst_n) begin
            m_state = 1'b0; m_prev_g = 1'b0; m_prev_p = 1'b0;
        end else begin
            if (clr)      m_state = 1'b0;
            else if (pre) m_state = 1'b1;
            else if (wr)  m_state = ref_next(cfg_mode, m_state, d, j_in, k_in, s_in, r_in);
            m_prev_g = glob_clk; m_prev_p = term_clk;
        end
        @(posedge clk);
        @(negedge clk);
        if (clr)                            exp_q = 1'b0;
        else if (pre)                       exp_q = 1'b1;
        else if (cfg_mode == 3'd4 && sel)   exp_q = d;
        else                                exp_q = m_state;
        t = (tag == "") ? tag_for(clr, pre, cfg_mode) : tag;
        check(t, q, exp_q);
    endtask

    task automatic rise_glob(string tag);
        glob_clk = 1'b0; step(tag);
        glob_clk = 1'b1; step(tag);
    endtask

    task automatic rise_term(string tag);
        term_clk = 1'b0; step(tag);
        term_clk = 1'b1; step(tag);
    endtask

    task automatic set_cfg(logic [2:0] m, logic [1:0] src, logic cs, logic ce);
        cfg_mode = m; cfg_dsrc = src; cfg_clk_sel = cs; cfg_ce_en = ce;
    endtask

    initial begin
        void'($urandom(32'h5EED_0C31));
        rst_n = 1'b0;
        set_cfg(3'd0, 2'd0, 1'b0, 1'b0);
        cfg_clr_sel = 2'b00; cfg_pre_en = 1'b0;
        {xor_in, data_term, pin_in, j_in, k_in, s_in, r_in} = '0;
        {glob_clk, term_clk, en_term, glob_clr, clr_term, set_term} = '0;
        m_state = 1'b0; m_prev_g = 1'b0; m_prev_p = 1'b0;
        @(negedge clk);

        // R12: reset leaves the bit at zero.
        step("R12"); step("R12");
        rst_n = 1'b1;
        step("R12");

        // R1: each source code feeds a D flip-flop; the selected one differs.
        for (int src = 0; src < 4; src++) begin
            for (int v = 0; v < 2; v++) begin
                cfg_dsrc  = 2'(src);
                xor_in    = (src == 0 || src == 3) ? v[0] : !v[0];
                data_term = (src == 1) ? v[0] : !v[0];
                pin_in    = (src == 2) ? v[0] : !v[0];
                rise_glob("R1");
                check("R1", q, v[0]);
            end
        end

        // R2: D mode with data changing while the clock stays high holds.
        set_cfg(3'd0, 2'd0, 1'b0, 1'b0);
        xor_in = 1'b1; rise_glob("R2");
        xor_in = 1'b0; step("R2"); check("R2", q, 1'b1);

        // R3: T mode toggles on data 1, holds on data 0.
        set_cfg(3'd1, 2'd0, 1'b0, 1'b0);
        xor_in = 1'b1; rise_glob("R3"); rise_glob("R3");
        xor_in = 1'b0; rise_glob("R3");

        // R4: all four JK combinations.
        set_cfg(3'd2, 2'd0, 1'b0, 1'b0);
        {j_in, k_in} = 2'b10; rise_glob("R4"); check("R4", q, 1'b1);
        {j_in, k_in} = 2'b00; rise_glob("R4"); check("R4", q, 1'b1);
        {j_in, k_in} = 2'b11; rise_glob("R4"); check("R4", q, 1'b0);
        {j_in, k_in} = 2'b11; rise_glob("R4"); check("R4", q, 1'b1);
        {j_in, k_in} = 2'b01; rise_glob("R4"); check("R4", q, 1'b0);

        // R5: SR set, both high holds, reset, both low holds.
        set_cfg(3'd3, 2'd0, 1'b0, 1'b0);
        {s_in, r_in} = 2'b10; rise_glob("R5"); check("R5", q, 1'b1);
        {s_in, r_in} = 2'b11; rise_glob("R5"); check("R5", q, 1'b1);
        {s_in, r_in} = 2'b01; rise_glob("R5"); check("R5", q, 1'b0);
        {s_in, r_in} = 2'b00; rise_glob("R5"); check("R5", q, 1'b0);

        // R6: latch passes data while high and holds it once low.
        set_cfg(3'd4, 2'd2, 1'b0, 1'b0);
        glob_clk = 1'b1; pin_in = 1'b1; step("R6"); check("R6", q, 1'b1);
        pin_in = 1'b0; step("R6"); check("R6", q, 1'b0);
        pin_in = 1'b1; step("R6");
        glob_clk = 1'b0; step("R6");
        pin_in = 1'b0; step("R6"); check("R6", q, 1'b1);

        // R7: term clock selected; global clock edges do nothing.
        set_cfg(3'd0, 2'd1, 1'b1, 1'b0);
        data_term = 1'b0; rise_term("R7"); term_clk = 1'b0; step("R7");
        data_term = 1'b1; rise_glob("R7"); check("R7", q, 1'b0);
        rise_term("R7"); check("R7", q, 1'b1);

        // R8: low enable blocks global edges but not term-clock edges.
        set_cfg(3'd0, 2'd1, 1'b0, 1'b1);
        en_term = 1'b0; data_term = 1'b0; rise_glob("R8"); check("R8", q, 1'b1);
        en_term = 1'b1; rise_glob("R8"); check("R8", q, 1'b0);
        set_cfg(3'd0, 2'd1, 1'b1, 1'b1);
        en_term = 1'b0; data_term = 1'b1; term_clk = 1'b0;
        rise_term("R8"); check("R8", q, 1'b1);

        // R9: each clear source code, then clear released keeps zero.
        for (int cs = 0; cs < 4; cs++) begin
            cfg_clr_sel = 2'(cs);
            {glob_clr, clr_term} = 2'b10; step("R9");
            check("R9", q, (cs == 1 || cs == 3) ? 1'b0 : m_state);
            {glob_clr, clr_term} = 2'b01; step("R9");
            check("R9", q, (cs >= 2) ? 1'b0 : m_state);
            {glob_clr, clr_term} = 2'b00; step("R9");
        end

        // R10: preset sets the bit; clear beats preset; disabled preset is ignored.
        cfg_clr_sel = 2'b01; cfg_pre_en = 1'b1;
        set_term = 1'b1; step("R10"); check("R10", q, 1'b1);
        glob_clr = 1'b1; step("R10"); check("R10", q, 1'b0);
        glob_clr = 1'b0; set_term = 1'b0; step("R10"); check("R10", q, 1'b0);
        cfg_pre_en = 1'b0; set_term = 1'b1; step("R10"); check("R10", q, 1'b0);
        set_term = 1'b0;

        // R11: reserved codes hold through edges.
        cfg_clk_sel = 1'b0; cfg_ce_en = 1'b0;
        for (int m = 5; m < 8; m++) begin
            cfg_mode = 3'(m); xor_in = 1'b1; {j_in, k_in, s_in} = 3'b111;
            rise_glob("R11"); check("R11", q, 1'b0);
        end

        // Random phase: configuration changes every 16 cycles.
        for (int i = 0; i < 3000; i++) begin
            if (i % 16 == 0) begin
                cfg_mode    = 3'($urandom % 8);
                cfg_dsrc    = 2'($urandom % 4);
                cfg_clk_sel = 1'($urandom % 2);
                cfg_ce_en   = 1'($urandom % 2);
                cfg_clr_sel = 2'($urandom % 4);
                cfg_pre_en  = 1'($urandom % 2);
            end
            {xor_in, data_term, pin_in, j_in, k_in, s_in, r_in} = 7'($urandom);
            glob_clk = 1'($urandom % 2);
            term_clk = 1'($urandom % 2);
            en_term  = ($urandom % 4) != 0;
            glob_clr = ($urandom % 12) == 0;
            clr_term = ($urandom % 12) == 0;
            set_term = ($urandom % 10) == 0;
            rst_n    = ($urandom % 400) != 0;
            step(rst_n ? "" : "R12");
            rst_n = 1'b1;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: q=%0b expected completion", q);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule